// File: doc/BRIEF.md
# Bit-Slip Serial-to-Parallel Converter

This block takes a recovered serial bit stream, one bit per accepted serial period, and assembles it into 16-bit parallel words. A clock enable marks the cycles in which a serial bit is present, so the block runs on a fast system clock. Each finished word is moved into an output register and announced with a one-cycle valid strobe. A derived word clock runs at one sixteenth of the serial bit rate.

A framer that is hunting for alignment can raise an asynchronous slip request. The request passes through a synchronizer. Once it has been seen high for enough serial periods, exactly one incoming bit is thrown away. This moves the word boundary one bit later in the stream. A framer repeats the request until its pattern lines up. Each request needs its own low-to-high transition, however long it stays high.

Top module: `slip_deserializer`

## Requirements
- R1: Every 16 accepted serial bits form one output word. `wordValid` is high for one cycle, in the cycle after the clock edge that accepts the 16th bit of the word.
- R2: Bit order: the first bit accepted within a word appears on `parWord[15]` and the last on `parWord[0]`.
- R3: `parWord` changes only in a cycle where `wordValid` is high, and then holds until the next strobe. `wordValid` is never high in two consecutive cycles.
- R4: The request is sampled on the clock edges with `bitEn` high, after a two-stage synchronizer. If it is seen high on fewer than 4 consecutive such edges, no bit is dropped. A pulse held for 3 serial periods leaves the stream intact.
- R5: A request seen high on 4 consecutive accepted edges drops exactly one bit. With `bitEn` held high, if `syncReq` is first high at the edge that accepts bit s, then bit s+5 is dropped. Holding the request longer drops nothing more. A further drop needs the request to be seen low and then high again.
- R6: The dropped bit is placed in no word. The word counter holds during that period, so the word that contains a drop spans 17 serial periods.
- R7: On a clock edge with `bitEn` low, no bit is taken, no request sample is counted, and no strobe follows.
- R8: `wordClk` is high for the first 8 accepted bits of each word period and low for the last 8. It rises only in the cycle in which `wordValid` is high.
- R9: Synchronous reset clears `parWord` to 0, `wordValid` to 0, the word counter and the request qualification state. The first strobe after reset follows the 16th newly accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial bit per cycle with `bitEn` high |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Serial bit present this cycle |
| serialIn | input | 1 | Serial data bit |
| syncReq | input | 1 | Asynchronous slip request, active high |
| parWord | output | 16 | Last completed word, first-received bit in MSB |
| wordValid | output | 1 | One-cycle strobe marking a new `parWord` |
| wordClk | output | 1 | Word-rate clock, high for first half of word period |

## Verification
The assertions check the following on every cycle:
- the output word holds between strobes, and strobes are single-cycle;
- `wordClk` rises only together with a strobe;
- an idle enable produces no strobe;
- a drop needs at least four high request samples, never coincides with a word completion, and occurs at most once per request.

Only the bench scenarios can show the rest:
- that the right bit is the one removed;
- that a 3-period pulse leaves the stream intact while a 4-period one slips it;
- that a long hold slips once;
- that words spanning a drop stretch to 17 periods.

The bench shows these by comparing every word against a reference stream with the predicted bits removed.

// File: rtl/slipdes_pkg.sv
package slipdes_pkg;
  // Strobes the control path hands to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;   // take serialIn into the shift register
    logic dropBit;   // discard serialIn this period
    logic wordDone;  // this bit completes a word
  } deserStrobes_t;
endpackage

// File: rtl/slipdes_sync.sv
module slipdes_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/slipdes_ctrl.sv
module slipdes_ctrl
  import slipdes_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int MIN_SYNC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bitEn,
  input  logic          syncReq,
  output deserStrobes_t strb,
  output logic          syncLevel,
  output logic          wordClk
);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int RUN_W  = $clog2(MIN_SYNC + 1);
  localparam int HALF_W = WORD_W / 2;

  logic [CNT_W-1:0] wordCnt;
  logic [RUN_W-1:0] runLen;
  logic             slipDone;

  slipdes_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (syncReq),
    .syncOut (syncLevel)
  );

  always_comb begin
    strb.dropBit  = bitEn && syncLevel && !slipDone &&
                    (runLen == RUN_W'(MIN_SYNC - 1));
    strb.shiftEn  = bitEn && !strb.dropBit;
    strb.wordDone = strb.shiftEn && (wordCnt == CNT_W'(WORD_W - 1));
  end

  // Request qualification: count high samples, fire once per assertion.
  always_ff @(posedge clk) begin
    if (rst) begin
      runLen   <= '0;
      slipDone <= 1'b0;
    end else if (bitEn) begin
      if (!syncLevel) begin
        runLen   <= '0;
        slipDone <= 1'b0;
      end else if (strb.dropBit) begin
        slipDone <= 1'b1;
      end else if (!slipDone) begin
        runLen <= runLen + RUN_W'(1);
      end
    end
  end

  // Word position; frozen during a dropped bit.
  always_ff @(posedge clk) begin
    if (rst)               wordCnt <= '0;
    else if (strb.wordDone) wordCnt <= '0;
    else if (strb.shiftEn)  wordCnt <= wordCnt + CNT_W'(1);
  end

  assign wordClk = (wordCnt < CNT_W'(HALF_W));
endmodule

// File: rtl/slipdes_datapath.sv
module slipdes_datapath
  import slipdes_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  deserStrobes_t     strb,
  output logic [WORD_W-1:0] parWord,
  output logic              wordValid
);
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;

  assign nextWord = {shiftReg[WORD_W-2:0], serialIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      parWord   <= '0;
      wordValid <= 1'b0;
    end else begin
      if (strb.shiftEn)  shiftReg <= nextWord;
      if (strb.wordDone) parWord  <= nextWord;
      wordValid <= strb.wordDone;
    end
  end
endmodule

// File: rtl/slip_deserializer.sv
module slip_deserializer
  import slipdes_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int MIN_SYNC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              serialIn,
  input  logic              syncReq,
  output logic [WORD_W-1:0] parWord,
  output logic              wordValid,
  output logic              wordClk
);
  deserStrobes_t strb;
  logic          syncLevel;

  slipdes_ctrl #(
    .WORD_W      (WORD_W),
    .MIN_SYNC    (MIN_SYNC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bitEn     (bitEn),
    .syncReq   (syncReq),
    .strb      (strb),
    .syncLevel (syncLevel),
    .wordClk   (wordClk)
  );

  slipdes_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .serialIn  (serialIn),
    .strb      (strb),
    .parWord   (parWord),
    .wordValid (wordValid)
  );
endmodule

// File: rtl/slipdes_checker.sv
module slipdes_checker
  import slipdes_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int MIN_SYNC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bitEn,
  input deserStrobes_t     strb,
  input logic              syncLevel,
  input logic [WORD_W-1:0] parWord,
  input logic              wordValid,
  input logic              wordClk
);
  localparam int RUN_W = $clog2(MIN_SYNC + 1);

  logic [RUN_W-1:0] hiRun;
  logic             gotDrop;

  // Independent tally of high request samples (saturating) and drops.
  always_ff @(posedge clk) begin
    if (rst) begin
      hiRun   <= '0;
      gotDrop <= 1'b0;
    end else if (bitEn) begin
      if (!syncLevel) begin
        hiRun   <= '0;
        gotDrop <= 1'b0;
      end else begin
        if (hiRun != RUN_W'(MIN_SYNC)) hiRun <= hiRun + RUN_W'(1);
        if (strb.dropBit) gotDrop <= 1'b1;
      end
    end
  end

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wordValid |-> $stable(parWord));

  assert_valid_in_high_R8: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> wordClk);

  assert_clk_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(wordClk) |-> wordValid);

  assert_idle_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> !wordValid);

  assert_drop_width_R4: assert property (@(posedge clk) disable iff (rst)
    strb.dropBit |-> (hiRun >= RUN_W'(MIN_SYNC - 1)));

  assert_one_drop_R5: assert property (@(posedge clk) disable iff (rst)
    strb.dropBit |-> !gotDrop);

  assert_drop_no_word_R6: assert property (@(posedge clk) disable iff (rst)
    strb.dropBit |-> (!strb.wordDone && !strb.shiftEn));
endmodule

bind slip_deserializer slipdes_checker #(
  .WORD_W   (WORD_W),
  .MIN_SYNC (MIN_SYNC)
) chk (
  .clk       (clk),
  .rst       (rst),
  .bitEn     (bitEn),
  .strb      (strb),
  .syncLevel (syncLevel),
  .parWord   (parWord),
  .wordValid (wordValid),
  .wordClk   (wordClk)
);

// File: tb/tb_slip_deserializer.sv
module tb_slip_deserializer;
  localparam int W     = 16;
  localparam int MAXB  = 4096;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bitEn = 1'b0;
  logic         serialIn = 1'b0;
  logic         syncReq = 1'b0;
  logic [W-1:0] parWord;
  logic         wordValid;
  logic         wordClk;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  logic stream  [0:MAXB-1];
  bit   dropped [0:MAXB-1];
  int   nIdx, ptr, prevEnd, prevCyc, wordsSeen, dropsTotal;
  bit   contMode, monOn;

  slip_deserializer dut (
    .clk(clk), .rst(rst), .bitEn(bitEn), .serialIn(serialIn),
    .syncReq(syncReq), .parWord(parWord), .wordValid(wordValid),
    .wordClk(wordClk)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic genBit(input int n);
    logic [31:0] h;
    h = n * 32'h9E3779B1;
    return h[17] ^ h[5] ^ h[29];
  endfunction

  // One clock: drive inputs, let one rising edge pass, return at falling edge.
  task automatic step(input logic en, input logic sy);
    bitEn   = en;
    syncReq = sy;
    if (en) begin
      serialIn = genBit(nIdx + 977 * int'(contMode));
      stream[nIdx] = serialIn;
      nIdx++;
    end else begin
      serialIn = ~serialIn;
    end
    @(negedge clk);
  endtask

  task automatic doReset(input bit cont);
    monOn = 0;
    rst = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < MAXB; i++) dropped[i] = 0;
    nIdx = 0; ptr = 0; prevEnd = -1; prevCyc = 0; wordsSeen = 0; dropsTotal = 0;
    contMode = cont;
    check(parWord == '0, "R9 reset word", int'(parWord), 0);
    check(wordValid == 1'b0, "R9 reset strobe", int'(wordValid), 0);
    monOn = 1;
  endtask

  // Request held for wid accepted periods, then low for gap periods.
  task automatic syncPulse(input int wid, input int gap);
    int s;
    s = nIdx;
    if (wid >= 4) begin
      dropped[s + 5] = 1;  // R5: fourth high sample after two-stage sync
      dropsTotal++;
    end
    for (int i = 0; i < wid; i++) step(1'b1, 1'b1);
    for (int i = 0; i < gap; i++) step(1'b1, 1'b0);
  endtask

  // Monitor: compare each word with the reference stream minus dropped bits.
  always @(negedge clk) begin
    if (monOn && !rst && wordValid) begin
      logic [W-1:0] exp;
      int dIn;
      exp = '0;
      dIn = 0;
      for (int j = 0; j < W; j++) begin
        while (dropped[ptr]) begin ptr++; dIn++; end
        exp = {exp[W-2:0], stream[ptr]};
        ptr++;
      end
      check(parWord == exp, "R1/R2 word content", int'(parWord), int'(exp));
      check(wordClk == 1'b1, "R8 clock high at strobe", int'(wordClk), 1);
      if (contMode && wordsSeen > 0)
        check(cyc - prevCyc == W + dIn, "R6 word period", cyc - prevCyc, W + dIn);
      prevCyc = cyc;
      prevEnd = ptr - 1;
      wordsSeen++;
    end
  end

  task automatic checkWordCount(input string req);
    int expW;
    expW = (nIdx - dropsTotal) / W;
    check(wordsSeen == expW, req, wordsSeen, expW);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    // Segment 1: continuous bits, latency of first word.
    doReset(1'b1);
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0);
    check(wordValid == 1'b0, "R9 no strobe before 16 bits", int'(wordValid), 0);
    step(1'b1, 1'b0);
    check(wordValid == 1'b1, "R1 strobe after 16th bit", int'(wordValid), 1);
    step(1'b1, 1'b0);
    check(wordValid == 1'b0, "R3 strobe one cycle", int'(wordValid), 0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    check(wordClk == 1'b1, "R8 clock high early", int'(wordClk), 1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    check(wordClk == 1'b0, "R8 clock low late", int'(wordClk), 0);
    for (int i = 0; i < 140; i++) step(1'b1, 1'b0);
    checkWordCount("R1 words in plain run");

    // Segment 2: slip requests of several widths.
    doReset(1'b1);
    for (int i = 0; i < 37; i++) step(1'b1, 1'b0);
    syncPulse(3, 30);     // R4: too short
    checkWordCount("R4 short pulse ignored");
    syncPulse(4, 30);     // R5: minimum width
    syncPulse(2, 25);     // R4
    syncPulse(40, 20);    // R5: long hold, one drop
    syncPulse(4, 7);      // R5: new assertion after low
    syncPulse(5, 19);
    for (int pos = 0; pos < 16; pos++) begin
      syncPulse(4, 9 + pos);  // sweep slip across word positions, R6
    end
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    checkWordCount("R5 words after slips");

    // Segment 3: enable gaps, with a request spanning idle cycles.
    doReset(1'b0);
    for (int i = 0; i < 600; i++) step((i % 3) != 2 && (i % 7) != 5, 1'b0);
    checkWordCount("R7 words with enable gaps");
    begin
      logic [W-1:0] held;
      bitEn = 1'b0;
      @(negedge clk);
      held = parWord;
      for (int i = 0; i < 40; i++) step(1'b0, (i % 4) != 0);
      check(parWord == held, "R7 idle keeps word", int'(parWord), int'(held));
      check(wordValid == 1'b0, "R7 idle no strobe", int'(wordValid), 0);
    end
    for (int i = 0; i < 64; i++) step(1'b1, 1'b0);
    checkWordCount("R4 idle-cycle request ignored");

    step(1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule